// File: doc/BRIEF.md
# Serial Converter Configuration and Result Port

This block is the digital face of a 10-bit successive-approximation converter. A host reaches it over a four-wire full-duplex link: an active-low select, a shift clock, a data line into the block and a data line out of it. Inside one select-low frame, the block takes in an 8-bit setup word one bit per rising shift-clock edge. On the same edges it returns the result of the previous conversion, changing the output bit on each falling edge. The setup word is decoded into channel, input-mode, polarity, bit-order and word-length fields, and these are handed to the conversion sequencer together with a one-cycle valid pulse and a five-shift-clock sample window.

The block runs on a fast system clock. The four link inputs and the conversion clock are resynchronised and edge-detected inside it. The sequencer delivers each finished 10-bit result as offset binary through a load strobe. At the start of the next frame the port formats that result with the setup that requested it: straight binary or two's complement, MSB or LSB first, and trimmed or padded to 8, 10, 12 or 16 bits. The output enable follows the select, so a pad driver can release the line between frames.

Top module: `adcport_top`

## Requirements
- R1: After reset the output enable is low, the sample window is closed and the decoded setup reads single-ended, channel select 0, unipolar, MSB first, word code 01. The first result word shifted out after reset is all zeros.
- R2: The output enable is high while select is low and goes low after select rises, including when a frame is cut short.
- R3: After select falls, shift-clock edges are ignored until two falling edges of the conversion clock have been seen. Setup bits clocked earlier have no effect.
- R4: Setup bits are captured on rising shift-clock edges, first bit to bit 7. Bit 7 is single-ended (1) or differential (0), bit 6 is odd/sign, bits 5:4 are select, bit 3 is unipolar (1) or bipolar (0), bit 2 is MSB-first (1), and bits 1:0 are the word code. Only when the eighth bit arrives are the fields updated and `cfgValid` pulsed once. A frame with fewer bits leaves the setup unchanged. Bits after the eighth are ignored.
- R5: `cfgChSel` presents {bit5, bit4, bit6} of the setup, and `cfgSingle` presents bit 7.
- R6: The first result bit is on `sdo` as soon as the frame is armed. Each later bit appears after a falling shift-clock edge, so it is stable on the next rising edge.
- R7: Word code 00, 01, 10 and 11 select 8, 10, 12 and 16 output bits.
- R8: With MSB-first the result leaves from bit 9 down. Otherwise it leaves from the lowest kept bit up.
- R9: In unipolar mode the offset-binary result is sent unchanged. In bipolar mode its bit 9 is inverted, giving two's complement.
- R10: In an 8-bit word the two lowest result bits are dropped, in either order. In 12- and 16-bit words the bits after the ten result bits are zero, and every bit after the word up to the end of the frame is also zero.
- R11: A frame returns the result last loaded by `resultLoad`, formatted with the setup in force when that frame was armed, which is the one received in the previous complete frame.
- R12: `sampleActive` rises when the eighth setup bit is captured and falls after five further falling shift-clock edges, or when select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Frame select, active low |
| sclk | input | 1 | Shift clock from the host |
| sdi | input | 1 | Serial setup data from the host |
| convClk | input | 1 | Conversion clock, used for arming after select |
| resultData | input | 10 | Finished conversion, offset binary |
| resultLoad | input | 1 | Strobe that stores `resultData` |
| sdo | output | 1 | Serial result data |
| sdoOe | output | 1 | Output enable for the `sdo` pad driver |
| cfgValid | output | 1 | One-cycle pulse when a new setup is decoded |
| cfgSingle | output | 1 | Single-ended (1) or differential (0) |
| cfgChSel | output | 3 | Channel select {sel1, sel0, odd/sign} |
| cfgUnipolar | output | 1 | Unipolar (1) or bipolar (0) |
| cfgMsbFirst | output | 1 | MSB-first (1) or LSB-first (0) |
| cfgWordCode | output | 2 | Output word-length code |
| sampleActive | output | 1 | Analog sample window |

## Verification
The link inputs pass two synchroniser stages and one edge-detect register, and the shift register or counter they feed adds one more. Each result therefore trails its stimulus by about four system clocks. The bench holds every shift-clock phase and each conversion-clock phase for at least four system clocks, and samples `sdo` and `sampleActive` at the end of the low phase, eight clocks after the preceding fall and before the next rise. The decoded setup, the valid count and the output enable are read six clocks after select rises, when all synchroniser paths have settled.

// File: rtl/adcport_pkg.sv
package adcport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2
  } portState_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadOut;    // frame armed: format stored result into the shifter
    logic shiftOut;   // falling shift-clock edge: advance the output
    logic captureIn;  // rising shift-clock edge: take a setup bit
    logic commitCfg;  // last setup bit: update the decoded setup
    logic driveData;  // frame armed: present the shifter MSB on sdo
  } portStrobe_t;

  // Setup word field positions (bit 7 arrives first)
  localparam int POS_SINGLE = 7;
  localparam int POS_ODD    = 6;
  localparam int POS_SEL1   = 5;
  localparam int POS_SEL0   = 4;
  localparam int POS_UNI    = 3;
  localparam int POS_MSBF   = 2;
  localparam int POS_WL1    = 1;
  localparam int POS_WL0    = 0;

  // single-ended, ch 0, unipolar, MSB first, 10-bit
  localparam logic [7:0] CFG_RESET = 8'b1000_1101;

  function automatic int wordLenOf(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 10;
      2'b10:   return 12;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/adcport_sync.sv
module adcport_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  input  logic [WIDTH-1:0] resetVal,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= resetVal;
          else        stage[g] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= resetVal;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/adcport_ctrl.sv
module adcport_ctrl
  import adcport_pkg::*;
#(
  parameter int CFG_BITS      = 8,
  parameter int ARM_EDGES     = 2,
  parameter int SAMPLE_CYCLES = 5,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csN,
  input  logic        sclk,
  input  logic        sdi,
  input  logic        convClk,
  output portStrobe_t strb,
  output logic        sdiBit,
  output logic        sdoOe,
  output logic        sampleActive
);

  localparam int IN_W   = $clog2(CFG_BITS + 1);
  localparam int ARM_W  = (ARM_EDGES > 1) ? $clog2(ARM_EDGES) : 1;
  localparam int SMP_W  = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam logic [IN_W-1:0]  IN_FULL  = IN_W'(CFG_BITS);
  localparam logic [IN_W-1:0]  IN_LAST  = IN_W'(CFG_BITS - 1);
  localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(ARM_EDGES - 1);
  localparam logic [SMP_W-1:0] SMP_LAST = SMP_W'(SAMPLE_CYCLES - 1);

  // synchronised inputs: {csN, sclk, sdi, convClk}
  logic [3:0] syncOut;
  logic       csLowS, sclkS, sdiS, convS;
  logic       sclkPrev, convPrev;
  logic       sclkRise, sclkFall, convFall;

  adcport_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({csN, sclk, sdi, convClk}),
    .resetVal(4'b1000),
    .syncOut (syncOut)
  );

  assign csLowS = ~syncOut[3];
  assign sclkS  = syncOut[2];
  assign sdiS   = syncOut[1];
  assign convS  = syncOut[0];
  assign sdiBit = sdiS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      convPrev <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      convPrev <= convS;
    end
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign convFall = ~convS & convPrev;

  portState_e       state;
  logic [ARM_W-1:0] convCnt;
  logic [IN_W-1:0]  inCnt;
  logic [SMP_W-1:0] sampleCnt;
  logic             armNow;

  assign armNow = (state == ST_WAIT) && csLowS && convFall && (convCnt == ARM_LAST);

  always_comb begin
    strb           = '0;
    strb.loadOut   = armNow;
    strb.driveData = (state == ST_ACTIVE) && csLowS;
    strb.captureIn = (state == ST_ACTIVE) && csLowS && sclkRise && (inCnt < IN_FULL);
    strb.commitCfg = strb.captureIn && (inCnt == IN_LAST);
    strb.shiftOut  = (state == ST_ACTIVE) && csLowS && sclkFall;
  end

  // frame state, arming count, setup-bit count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      convCnt <= '0;
      inCnt   <= '0;
      sdoOe   <= 1'b0;
    end else begin
      sdoOe <= csLowS;
      case (state)
        ST_IDLE: begin
          if (csLowS) begin
            state   <= ST_WAIT;
            convCnt <= '0;
            inCnt   <= '0;
          end
        end
        ST_WAIT: begin
          if (!csLowS) begin
            state <= ST_IDLE;
          end else if (convFall) begin
            if (convCnt == ARM_LAST) state <= ST_ACTIVE;
            else                     convCnt <= convCnt + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (!csLowS)             state <= ST_IDLE;
          else if (strb.captureIn) inCnt <= inCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // sample window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleActive <= 1'b0;
      sampleCnt    <= '0;
    end else if (!csLowS) begin
      sampleActive <= 1'b0;
      sampleCnt    <= '0;
    end else if (strb.commitCfg) begin
      sampleActive <= 1'b1;
      sampleCnt    <= '0;
    end else if (sampleActive && sclkFall) begin
      if (sampleCnt == SMP_LAST) sampleActive <= 1'b0;
      else                       sampleCnt <= sampleCnt + 1'b1;
    end
  end

  // R2
  sdo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csLowS |=> !sdoOe);

  // R3
  arm_after_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && $past(state) == ST_WAIT) |-> $past(convFall));

  // R4
  cfg_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inCnt <= IN_FULL);

  // R12
  sample_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commitCfg |=> sampleActive);

endmodule

// File: rtl/adcport_datapath.sv
module adcport_datapath
  import adcport_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int WORD_MAX = 16,
  parameter int CFG_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  portStrobe_t         strb,
  input  logic                sdiBit,
  input  logic [RES_BITS-1:0] resultData,
  input  logic                resultLoad,
  output logic                sdo,
  output logic [CFG_BITS-1:0] cfgWord,
  output logic                cfgValid
);

  localparam logic [RES_BITS-1:0] SIGN_FLIP = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [CFG_BITS-1:0] cfgShift;
  logic [CFG_BITS-1:0] cfgReg;
  logic [RES_BITS-1:0] resultReg;
  logic [WORD_MAX-1:0] outShift;
  logic [RES_BITS-1:0] code;
  logic [WORD_MAX-1:0] loadWord;
  int                  wordLen;
  int                  keep;

  // stored conversion result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          resultReg <= '0;
    else if (resultLoad) resultReg <= resultData;
  end

  // setup word capture and commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgShift <= '0;
      cfgReg   <= CFG_RESET;
      cfgValid <= 1'b0;
    end else begin
      cfgValid <= strb.commitCfg;
      if (strb.captureIn) cfgShift <= {cfgShift[CFG_BITS-2:0], sdiBit};
      if (strb.commitCfg) cfgReg   <= {cfgShift[CFG_BITS-2:0], sdiBit};
    end
  end

  // result formatting: polarity, order, length
  always_comb begin
    code     = cfgReg[POS_UNI] ? resultReg : (resultReg ^ SIGN_FLIP);
    wordLen  = wordLenOf(cfgReg[POS_WL1:POS_WL0]);
    keep     = (wordLen < RES_BITS) ? wordLen : RES_BITS;
    loadWord = '0;
    for (int j = 0; j < RES_BITS; j++) begin
      if (j < keep) begin
        if (cfgReg[POS_MSBF]) loadWord[WORD_MAX-1-j] = code[RES_BITS-1-j];
        else                  loadWord[WORD_MAX-1-j] = code[RES_BITS-keep+j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             outShift <= '0;
    else if (strb.loadOut)  outShift <= loadWord;
    else if (strb.shiftOut) outShift <= {outShift[WORD_MAX-2:0], 1'b0};
  end

  assign sdo     = strb.driveData & outShift[WORD_MAX-1];
  assign cfgWord = cfgReg;

  // R9
  bipolar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadOut && !cfgReg[POS_UNI] && cfgReg[POS_MSBF])
      |=> outShift[WORD_MAX-1] == ~$past(resultReg[RES_BITS-1]));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commitCfg |=> $stable(cfgReg));

  // R10
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadOut && cfgReg[POS_WL1:POS_WL0] == 2'b11) |=> outShift[WORD_MAX-RES_BITS-1:0] == '0);

endmodule

// File: rtl/adcport_top.sv
module adcport_top
  import adcport_pkg::*;
#(
  parameter int RES_BITS      = 10,
  parameter int WORD_MAX      = 16,
  parameter int CFG_BITS      = 8,
  parameter int ARM_EDGES     = 2,
  parameter int SAMPLE_CYCLES = 5,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csN,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                convClk,
  input  logic [RES_BITS-1:0] resultData,
  input  logic                resultLoad,
  output logic                sdo,
  output logic                sdoOe,
  output logic                cfgValid,
  output logic                cfgSingle,
  output logic [2:0]          cfgChSel,
  output logic                cfgUnipolar,
  output logic                cfgMsbFirst,
  output logic [1:0]          cfgWordCode,
  output logic                sampleActive
);

  portStrobe_t         strb;
  logic                sdiBit;
  logic [CFG_BITS-1:0] cfgWord;

  adcport_ctrl #(
    .CFG_BITS     (CFG_BITS),
    .ARM_EDGES    (ARM_EDGES),
    .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uCtrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .csN         (csN),
    .sclk        (sclk),
    .sdi         (sdi),
    .convClk     (convClk),
    .strb        (strb),
    .sdiBit      (sdiBit),
    .sdoOe       (sdoOe),
    .sampleActive(sampleActive)
  );

  adcport_datapath #(
    .RES_BITS(RES_BITS),
    .WORD_MAX(WORD_MAX),
    .CFG_BITS(CFG_BITS)
  ) uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .sdiBit    (sdiBit),
    .resultData(resultData),
    .resultLoad(resultLoad),
    .sdo       (sdo),
    .cfgWord   (cfgWord),
    .cfgValid  (cfgValid)
  );

  assign cfgSingle   = cfgWord[POS_SINGLE];
  assign cfgChSel    = {cfgWord[POS_SEL1], cfgWord[POS_SEL0], cfgWord[POS_ODD]};
  assign cfgUnipolar = cfgWord[POS_UNI];
  assign cfgMsbFirst = cfgWord[POS_MSBF];
  assign cfgWordCode = cfgWord[POS_WL1:POS_WL0];

endmodule

// File: tb/tb_adcport_top.sv
module tb_adcport_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       sdi = 1'b0;
  logic       convClk = 1'b0;
  logic [9:0] resultData = '0;
  logic       resultLoad = 1'b0;
  logic       sdo, sdoOe, cfgValid, cfgSingle, cfgUnipolar, cfgMsbFirst, sampleActive;
  logic [2:0] cfgChSel;
  logic [1:0] cfgWordCode;

  int checks = 0;
  int errors = 0;
  int validCount = 0;
  bit done = 1'b0;

  logic [7:0] prevCfg = 8'h8D;
  logic [9:0] prevRaw = '0;

  always #10 clk = ~clk;

  adcport_top dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .sdi(sdi), .convClk(convClk),
    .resultData(resultData), .resultLoad(resultLoad), .sdo(sdo), .sdoOe(sdoOe),
    .cfgValid(cfgValid), .cfgSingle(cfgSingle), .cfgChSel(cfgChSel),
    .cfgUnipolar(cfgUnipolar), .cfgMsbFirst(cfgMsbFirst), .cfgWordCode(cfgWordCode),
    .sampleActive(sampleActive)
  );

  always @(posedge clk) if (cfgValid) validCount <= validCount + 1;

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expBit(input logic [7:0] c, input logic [9:0] raw, input int i);
    int wl, keep;
    logic [9:0] code;
    code = c[3] ? raw : (raw ^ 10'h200);
    case (c[1:0])
      2'b00: wl = 8;
      2'b01: wl = 10;
      2'b10: wl = 12;
      default: wl = 16;
    endcase
    keep = (wl < 10) ? wl : 10;
    if (i >= keep) return 1'b0;
    return c[2] ? code[9-i] : code[10-keep+i];
  endfunction

  task automatic runFrame(input logic [7:0] cfg, input int nBits, input logic [9:0] nextRaw,
                          input bit early, input string tag);
    int vBefore;
    logic [15:0] gotWord, expWord;
    bit sampleOk;
    int sampleBad;
    vBefore  = validCount;
    gotWord  = '0;
    expWord  = '0;
    sampleOk = 1'b1;
    sampleBad = 0;
    csN = 1'b0;
    waitClk(6);
    // R2 driven while selected
    check(sdoOe == 1'b1, "R2 oe while selected", int'(sdoOe), 1);
    if (early) begin
      for (int k = 0; k < 8; k++) begin
        sdi = 1'b1; waitClk(4); sclk = 1'b1; waitClk(4); sclk = 1'b0;
      end
      sdi = 1'b0;
    end
    for (int k = 0; k < 2; k++) begin
      convClk = 1'b1; waitClk(4); convClk = 1'b0; waitClk(4);
    end
    waitClk(4);
    for (int i = 0; i < nBits; i++) begin
      sdi = (i < 8) ? cfg[7-i] : 1'b0;
      waitClk(8);
      gotWord[15-i] = sdo;
      expWord[15-i] = expBit(prevCfg, prevRaw, i);
      if (nBits >= 13 && sampleActive !== ((i >= 8) && (i <= 11))) begin
        sampleOk = 1'b0;
        sampleBad = i;
      end
      sclk = 1'b1; waitClk(8); sclk = 1'b0;
    end
    check(gotWord == expWord, tag, int'(gotWord), int'(expWord));
    if (nBits >= 13)
      check(sampleOk, "R12 sample window at bit index", sampleBad, 0);
    csN = 1'b1;
    waitClk(6);
    check(sdoOe == 1'b0, "R2 oe released", int'(sdoOe), 0);
    if (nBits >= 8) begin
      prevCfg = cfg;
      check(validCount == vBefore + 1, "R4 one valid pulse", validCount - vBefore, 1);
    end else begin
      check(validCount == vBefore, "R4 short frame no pulse", validCount - vBefore, 0);
    end
    // R5 R7 decoded setup fields
    check({cfgSingle, cfgChSel, cfgUnipolar, cfgMsbFirst, cfgWordCode} ==
          {prevCfg[7], prevCfg[5], prevCfg[4], prevCfg[6], prevCfg[3], prevCfg[2], prevCfg[1:0]},
          "R4 R5 decoded setup",
          int'({cfgSingle, cfgChSel, cfgUnipolar, cfgMsbFirst, cfgWordCode}),
          int'({prevCfg[7], prevCfg[5], prevCfg[4], prevCfg[6], prevCfg[3], prevCfg[2], prevCfg[1:0]}));
    resultData = nextRaw; resultLoad = 1'b1; waitClk(1); resultLoad = 1'b0;
    prevRaw = nextRaw;
    waitClk(2);
  endtask

  initial begin
    int n;
    logic [9:0] pats [4];
    logic [7:0] c;
    pats[0] = 10'h3FF; pats[1] = 10'h200; pats[2] = 10'h1FF; pats[3] = 10'h000;
    waitClk(3);
    rst_n = 1'b1;
    waitClk(3);
    // R1 reset state
    check(sdoOe == 1'b0 && sampleActive == 1'b0, "R1 reset oe and window",
          int'({sdoOe, sampleActive}), 0);
    check({cfgSingle, cfgChSel, cfgUnipolar, cfgMsbFirst, cfgWordCode} == 8'h8D,
          "R1 reset setup", int'({cfgSingle, cfgChSel, cfgUnipolar, cfgMsbFirst, cfgWordCode}), 8'h8D);
    n = 0;
    // R6 R7 R8 R9 R10 R11 sweep over every setup field
    for (int wl = 0; wl < 4; wl++)
      for (int ms = 0; ms < 2; ms++)
        for (int un = 0; un < 2; un++)
          for (int ch = 0; ch < 8; ch++) begin
            logic [9:0] nr;
            c  = {ch[0] ^ ch[1], ch[2], ch[1], ch[0], un[0], ms[0], wl[1:0]};
            nr = (n % 5 == 0) ? pats[(n / 5) % 4] : 10'((n * 389 + 77) & 10'h3FF);
            runFrame(c, 16, nr, 1'b0, (n == 0) ? "R1 first word zero" : "R6 R7 R8 R9 R10 R11 word");
            n++;
          end
    // R3 early shift edges before arming are ignored
    runFrame(8'h02, 16, 10'h2A5, 1'b1, "R3 early edges word");
    check(cfgWordCode == 2'b10 && cfgUnipolar == 1'b0, "R3 setup after early edges",
          int'({cfgUnipolar, cfgWordCode}), 2);
    // R4 short frame keeps setup
    runFrame(8'hFF, 4, 10'h155, 1'b0, "R4 short frame word");
    // R11 next frame uses setup from the last complete frame
    runFrame(8'h8D, 16, 10'h000, 1'b0, "R11 after short frame word");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule